// File: doc/BRIEF.md
# Token-Loss Reconfiguration Timer Unit

This unit sits beside the transmit sequencer of a token-passing network node with an 8-bit node ID. It watches a line-activity input. When the line stays quiet for longer than a set number of microsecond ticks, it takes the token to be lost. It then waits through a backoff whose length grows as the node ID falls: the slot time multiplied by (255 minus own ID). If the line stays quiet until that backoff ends, the unit raises the "this node caused reconfiguration" flag and gives a one-cycle interrupt request. It then offers the sequencer a stream of destination IDs to invite. The first ID is its own, and each later ID is one below the one before.

The destination stream uses valid/ready. `inv_valid` stays high for the whole sweep. `inv_dest` holds still while `inv_ready` is low and moves on by one ID, wrapping downward, on each cycle where both are high. The sequencer ends the sweep by pulsing `token_passed` once the token has been handed on. The unit also runs a separate long reconfiguration timer. Each time that timer runs out, it pulses `burst_start` to ask for a reconfigure burst. Time is counted with a 1 µs `tick` enable. A prescaler selected by `rate_sel` stretches every timeout in proportion for slower data rates.

Top module: `token_recon_timer`

## Requirements
- R1: After reset `inv_valid`, `recon_irq`, `my_recon` and `burst_start` are all 0.
- R2: A token loss is declared once the line has been idle for IDLE_US+1 scaled ticks in a row (default 83), and the backoff then starts. Any cycle with `line_act` high sets the idle count back to zero.
- R3: The backoff lasts SLOT_US*(255-node_id) scaled ticks (default SLOT_US=146). With one scaled tick per clock, `inv_valid` first reads high exactly IDLE_US+3+SLOT_US*(255-node_id) clock edges after `line_act` falls. An ID of 255 gives a zero-length backoff.
- R4: The first destination offered after the backoff equals `node_id`.
- R5: On each edge where `inv_valid` and `inv_ready` are both high and `token_passed` is low, `inv_dest` drops by one, wrapping from 0 to 255. While `inv_ready` is low, `inv_dest` holds its value.
- R6: `line_act` seen during the backoff cancels it without any invitation, and idle monitoring starts again from zero.
- R7: `token_passed` during the sweep drops `inv_valid` on the next edge and returns the unit to monitoring.
- R8: `my_recon` is set on the edge where the backoff expires. It stays set until `host_clr` or reset. If the set and the clear fall on the same edge, the set wins.
- R9: `recon_irq` is a single-cycle pulse on the same edge where the sweep begins.
- R10: `burst_start` pulses for one cycle every RECON_US scaled ticks, counted from reset. A `token_passed` pulse restarts the count, so the next pulse comes RECON_US+1 edges after the edge that samples `token_passed`.
- R11: `rate_sel` = k counts one scaled tick for every 2^k `tick` pulses (k = 0..3), which stretches all of the above timeouts by 2^k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 1 µs time-base enable |
| rate_sel | input | 2 | Data-rate prescaler select, divide by 2^rate_sel |
| line_act | input | 1 | Receive-line activity seen this cycle |
| node_id | input | 8 | Own node ID |
| host_clr | input | 1 | Host strobe clearing `my_recon` |
| token_passed | input | 1 | Sequencer reports the token was handed on; ends the sweep and restarts the long timer |
| inv_ready | input | 1 | Sequencer accepts the current destination |
| inv_valid | output | 1 | A destination ID to invite is offered |
| inv_dest | output | 8 | Destination ID to invite |
| recon_irq | output | 1 | One-cycle pulse when this node starts a reconfiguration |
| my_recon | output | 1 | Sticky flag: this node caused the last reconfiguration |
| burst_start | output | 1 | One-cycle request to send a reconfigure burst |

## Verification
The assertions assume that `node_id` changes only while the unit is monitoring. This keeps the first-destination check meaningful. They also assume that `token_passed` is pulsed rather than held. The stimulus changes `node_id` only while `line_act` is high, before each idle period begins, and it pulses `token_passed` for one cycle at the end of each sweep. It drives `inv_ready` high and low during the sweep to exercise both the stall and the step rules. The stimulus also raises `line_act` in the middle of a backoff to show that the backoff is cancelled and restarted.

// File: rtl/token_recon_pkg.sv
package token_recon_pkg;
  typedef enum logic [1:0] {
    ST_MONITOR = 2'd0,
    ST_BACKOFF = 2'd1,
    ST_SWEEP   = 2'd2
  } recon_state_e;
endpackage

// File: rtl/rcfg_tick_scale.sv
module rcfg_tick_scale #(
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              stick
);
  generate
    if (RATE_W == 0) begin : g_bypass
      assign stick = tick;
    end else begin : g_prescale
      localparam int PW = (1 << RATE_W) - 1;
      logic [PW-1:0] pcnt;
      logic [PW-1:0] mask;

      assign mask  = (PW'(1) << rate_sel) - PW'(1);
      assign stick = tick && ((pcnt & mask) == mask);

      always_ff @(posedge clk) begin
        if (!rst_n)    pcnt <= '0;
        else if (tick) pcnt <= pcnt + PW'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/rcfg_idle_watch.sv
module rcfg_idle_watch #(
  parameter int IDLE_US = 82
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stick,
  input  logic line_act,
  output logic idle_seen
);
  localparam int CW = $clog2(IDLE_US + 2);
  localparam logic [CW-1:0] LIM = CW'(IDLE_US + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (line_act)            cnt <= '0;
    else if (stick && cnt != LIM) cnt <= cnt + CW'(1);
  end

  assign idle_seen = (cnt == LIM);
endmodule

// File: rtl/rcfg_long_timer.sv
module rcfg_long_timer #(
  parameter int RECON_US = 840000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stick,
  input  logic restart,
  output logic burst_start
);
  localparam int CW = $clog2(RECON_US + 1);
  localparam logic [CW-1:0] LAST = CW'(RECON_US - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      burst_start <= 1'b0;
    end else if (restart) begin
      cnt         <= '0;
      burst_start <= 1'b0;
    end else if (stick) begin
      if (cnt == LAST) begin
        cnt         <= '0;
        burst_start <= 1'b1;
      end else begin
        cnt         <= cnt + CW'(1);
        burst_start <= 1'b0;
      end
    end else begin
      burst_start <= 1'b0;
    end
  end
endmodule

// File: rtl/rcfg_backoff_sweep.sv
module rcfg_backoff_sweep
  import token_recon_pkg::*;
#(
  parameter int ID_W    = 8,
  parameter int SLOT_US = 146
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stick,
  input  logic            line_act,
  input  logic            idle_seen,
  input  logic [ID_W-1:0] node_id,
  input  logic            host_clr,
  input  logic            token_passed,
  input  logic            inv_ready,
  output logic            inv_valid,
  output logic [ID_W-1:0] inv_dest,
  output logic            recon_irq,
  output logic            my_recon
);
  localparam logic [ID_W-1:0] ID_TOP = '1;
  localparam int BO_W = $clog2(SLOT_US * ((1 << ID_W) - 1) + 1);

  recon_state_e    state;
  logic [BO_W-1:0] bo_cnt;
  logic [BO_W-1:0] bo_load;
  logic [ID_W-1:0] id_gap;
  logic            expire;

  assign id_gap  = ID_TOP - node_id;
  assign bo_load = BO_W'(SLOT_US) * BO_W'(id_gap);
  assign expire  = (state == ST_BACKOFF) && !line_act && (bo_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_MONITOR;
      bo_cnt    <= '0;
      inv_dest  <= '0;
      recon_irq <= 1'b0;
    end else begin
      recon_irq <= 1'b0;
      unique case (state)
        ST_MONITOR: begin
          if (idle_seen && !line_act) begin
            state  <= ST_BACKOFF;
            bo_cnt <= bo_load;
          end
        end
        ST_BACKOFF: begin
          if (line_act) begin
            state <= ST_MONITOR;
          end else if (expire) begin
            state     <= ST_SWEEP;
            inv_dest  <= node_id;
            recon_irq <= 1'b1;
          end else if (stick) begin
            bo_cnt <= bo_cnt - BO_W'(1);
          end
        end
        ST_SWEEP: begin
          if (token_passed)   state    <= ST_MONITOR;
          else if (inv_ready) inv_dest <= inv_dest - ID_W'(1);
        end
        default: state <= ST_MONITOR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        my_recon <= 1'b0;
    else if (expire)   my_recon <= 1'b1;
    else if (host_clr) my_recon <= 1'b0;
  end

  assign inv_valid = (state == ST_SWEEP);
endmodule

// File: rtl/token_recon_timer.sv
module token_recon_timer #(
  parameter int ID_W     = 8,
  parameter int RATE_W   = 2,
  parameter int IDLE_US  = 82,
  parameter int SLOT_US  = 146,
  parameter int RECON_US = 840000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              line_act,
  input  logic [ID_W-1:0]   node_id,
  input  logic              host_clr,
  input  logic              token_passed,
  input  logic              inv_ready,
  output logic              inv_valid,
  output logic [ID_W-1:0]   inv_dest,
  output logic              recon_irq,
  output logic              my_recon,
  output logic              burst_start
);
  logic stick;
  logic idle_seen;

  rcfg_tick_scale #(.RATE_W(RATE_W)) u_scale (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rate_sel(rate_sel), .stick(stick)
  );

  rcfg_idle_watch #(.IDLE_US(IDLE_US)) u_idle (
    .clk(clk), .rst_n(rst_n), .stick(stick), .line_act(line_act),
    .idle_seen(idle_seen)
  );

  rcfg_backoff_sweep #(.ID_W(ID_W), .SLOT_US(SLOT_US)) u_sweep (
    .clk(clk), .rst_n(rst_n), .stick(stick), .line_act(line_act),
    .idle_seen(idle_seen), .node_id(node_id), .host_clr(host_clr),
    .token_passed(token_passed), .inv_ready(inv_ready),
    .inv_valid(inv_valid), .inv_dest(inv_dest),
    .recon_irq(recon_irq), .my_recon(my_recon)
  );

  rcfg_long_timer #(.RECON_US(RECON_US)) u_long (
    .clk(clk), .rst_n(rst_n), .stick(stick), .restart(token_passed),
    .burst_start(burst_start)
  );
endmodule

// File: rtl/token_recon_checker.sv
module token_recon_checker #(
  parameter int ID_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            line_act,
  input logic [ID_W-1:0] node_id,
  input logic            host_clr,
  input logic            token_passed,
  input logic            inv_ready,
  input logic            inv_valid,
  input logic [ID_W-1:0] inv_dest,
  input logic            recon_irq,
  input logic            my_recon,
  input logic            burst_start
);
  p_first_dest_self_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inv_valid) |-> (inv_dest == node_id));

  p_dest_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_ready && !token_passed) |=>
      (inv_valid && inv_dest == $past(inv_dest) - ID_W'(1)));

  p_dest_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !inv_ready && !token_passed) |=> (inv_valid && $stable(inv_dest)));

  p_cancel_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_act && !inv_valid) |=> !inv_valid);

  p_sweep_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && token_passed) |=> !inv_valid);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (my_recon && !host_clr) |=> my_recon);

  p_flag_on_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inv_valid) |-> my_recon);

  p_irq_with_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    recon_irq |-> ($rose(inv_valid) && $past(!recon_irq)));

  p_burst_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> !burst_start);
endmodule

bind token_recon_timer token_recon_checker #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_act(line_act), .node_id(node_id),
  .host_clr(host_clr), .token_passed(token_passed), .inv_ready(inv_ready),
  .inv_valid(inv_valid), .inv_dest(inv_dest), .recon_irq(recon_irq),
  .my_recon(my_recon), .burst_start(burst_start)
);

// File: tb/token_recon_timer_tb_top.sv
`timescale 1ns/1ps
module token_recon_timer_tb_top;
  localparam int IDLE_US  = 82;
  localparam int SLOT_US  = 146;
  localparam int RECON_US = 3000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [1:0] rate_sel = 2'd0;
  logic       line_act = 1'b1;
  logic [7:0] node_id = 8'd0;
  logic       host_clr = 1'b0;
  logic       token_passed = 1'b0;
  logic       inv_ready = 1'b0;
  logic       inv_valid;
  logic [7:0] inv_dest;
  logic       recon_irq;
  logic       my_recon;
  logic       burst_start;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  token_recon_timer #(
    .IDLE_US(IDLE_US), .SLOT_US(SLOT_US), .RECON_US(RECON_US)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rate_sel(rate_sel),
    .line_act(line_act), .node_id(node_id), .host_clr(host_clr),
    .token_passed(token_passed), .inv_ready(inv_ready),
    .inv_valid(inv_valid), .inv_dest(inv_dest), .recon_irq(recon_irq),
    .my_recon(my_recon), .burst_start(burst_start)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sweep_delay(input int id);
    return IDLE_US + 3 + SLOT_US * (255 - id);
  endfunction

  // count clock edges (sampled at negedge) until inv_valid reads high
  task automatic wait_valid(output int n, input int lim);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!inv_valid && n < lim);
  endtask

  task automatic end_sweep();
    token_passed = 1'b1;
    line_act     = 1'b1;
    inv_ready    = 1'b0;
    @(negedge clk);
    token_passed = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(inv_valid == 1'b0, "R1 inv_valid", inv_valid, 0);
    chk(my_recon == 1'b0, "R1 my_recon", my_recon, 0);
    chk(recon_irq == 1'b0 && burst_start == 1'b0, "R1 pulses", recon_irq + burst_start, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_long_timer();
    int n;
    n = 0;
    do begin @(negedge clk); n++; end while (!burst_start && n < 2 * RECON_US);
    chk(n == RECON_US, "R10 first burst edge", n, RECON_US);
    @(negedge clk);
    chk(burst_start == 1'b0, "R10 burst width", burst_start, 0);
    repeat (1000) @(negedge clk);
    token_passed = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      token_passed = 1'b0;
      n++;
    end while (!burst_start && n < 2 * RECON_US);
    chk(n == RECON_US + 1, "R10 restart", n, RECON_US + 1);
  endtask

  task automatic t_zero_backoff();
    int n;
    node_id = 8'd255;
    @(negedge clk);
    line_act = 1'b0;
    wait_valid(n, 1000);
    chk(n == sweep_delay(255), "R2 R3 id 255 delay", n, sweep_delay(255));
    chk(inv_dest == 8'd255, "R4 dest own", inv_dest, 255);
    end_sweep();
    chk(inv_valid == 1'b0, "R7 stop", inv_valid, 0);
  endtask

  task automatic t_backoff_sweep();
    int n;
    node_id = 8'd250;
    host_clr = 1'b1;
    @(negedge clk);
    host_clr = 1'b0;
    line_act = 1'b0;
    wait_valid(n, 5000);
    chk(n == sweep_delay(250), "R3 id 250 delay", n, sweep_delay(250));
    chk(inv_dest == 8'd250, "R4 first dest", inv_dest, 250);
    chk(my_recon == 1'b1, "R8 set", my_recon, 1);
    chk(recon_irq == 1'b1, "R9 irq high", recon_irq, 1);
    inv_ready = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk(inv_dest == 8'(250 - k), "R5 step", inv_dest, 250 - k);
      if (k == 1) chk(recon_irq == 1'b0, "R9 irq single", recon_irq, 0);
    end
    inv_ready = 1'b0;
    repeat (2) @(negedge clk);
    chk(inv_dest == 8'd247 && inv_valid, "R5 hold", inv_dest, 247);
    end_sweep();
    chk(inv_valid == 1'b0, "R7 stop after step", inv_valid, 0);
  endtask

  task automatic t_wrap();
    int n;
    node_id = 8'd1;
    @(negedge clk);
    line_act = 1'b0;
    wait_valid(n, 40000);
    chk(n == sweep_delay(1), "R3 id 1 delay", n, sweep_delay(1));
    chk(inv_dest == 8'd1, "R4 id 1", inv_dest, 1);
    inv_ready = 1'b1;
    @(negedge clk);
    chk(inv_dest == 8'd0, "R5 to zero", inv_dest, 0);
    @(negedge clk);
    chk(inv_dest == 8'd255, "R5 wrap", inv_dest, 255);
    end_sweep();
  endtask

  task automatic t_cancel();
    int n;
    node_id = 8'd250;
    @(negedge clk);
    line_act = 1'b0;
    repeat (400) @(negedge clk);
    chk(inv_valid == 1'b0, "R6 still backing off", inv_valid, 0);
    line_act = 1'b1;
    @(negedge clk);
    line_act = 1'b0;
    wait_valid(n, 5000);
    chk(n == sweep_delay(250), "R6 R2 restart from zero", n, sweep_delay(250));
    end_sweep();
  endtask

  task automatic t_flag_clear();
    repeat (5) @(negedge clk);
    chk(my_recon == 1'b1, "R8 sticky", my_recon, 1);
    host_clr = 1'b1;
    @(negedge clk);
    host_clr = 1'b0;
    chk(my_recon == 1'b0, "R8 clear", my_recon, 0);
  endtask

  task automatic t_rate();
    int n;
    node_id  = 8'd255;
    rate_sel = 2'd1;
    @(negedge clk);
    line_act = 1'b0;
    wait_valid(n, 1000);
    chk(n >= 2 * (IDLE_US + 1) && n <= 2 * (IDLE_US + 1) + 3, "R11 divide by 2",
        n, 2 * (IDLE_US + 1) + 2);
    end_sweep();
    rate_sel = 2'd0;
  endtask

  initial begin
    t_reset();
    t_long_timer();
    t_zero_backoff();
    t_backoff_sweep();
    t_wrap();
    t_cancel();
    t_flag_clear();
    t_rate();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule